// File: doc/BRIEF.md
# Front-End Board Readout Sequencer

This block reads out one front-end board that carries six amplifier-shaper chips. Each chip puts its eighteen channels one after another onto a single analogue line, and each line feeds its own converter. A trigger arrives while the block is idle. The block then raises a hold strobe a programmable number of clock ticks later, so that the shaped pulse is frozen at its peak. The nominal figure is 180 ns after the trigger, and the hold edge needs roughly 10 ns accuracy. In calibration mode a charge-injection pulse starts a programmable lead time before the hold edge.

With the hold set, the block drives a channel select that all six chips share. It steps that select through eighteen slots. After each step it waits a programmable settling time and strobes all converters together. When the converters report, it sends out one word per chip for that slot. Every channel is read on every event and nothing is suppressed, so pedestals and noise stay visible. One event yields 108 words on a valid/ready stream.

Stream rules: `out_valid_o` and `out_data_o` hold steady until `out_ready_i` is high on a clock edge. No word is dropped or repeated, and any ready pattern is legal. The sequencer stalls while downstream holds off. The configuration inputs must stay steady while `busy_o` is high. The calibration mode is captured when the trigger is accepted.

Top module: `fe_readout_seq`

## Requirements
- R1: After reset, busy_o, hold_o, inject_o, conv_start_o and out_valid_o are all low.
- R2: A trigger sampled high on a clock edge while idle is accepted on that edge. hold_o rises max(hold_dly_i,1) clock edges after the accepting edge and stays high until the event ends.
- R3: With calib_i high at acceptance and inj_lead_i nonzero, inject_o rises max(hold_dly_i − inj_lead_i, 0) edges after the accepting edge and falls on the edge where hold_o rises. Otherwise inject_o never rises.
- R4: mux_sel_o walks 0,1,…,17 once per event. conv_start_o is a one-cycle pulse that rises settle_i+1 edges after the edge on which mux_sel_o changed or hold_o rose.
- R5: After the converters report (adc_valid_i high while a conversion is pending), the block emits six words for that slot, chip 0 to 5. It emits 108 words per event in slot-major order. Chip k's sample is adc_data_i[14k+13:14k].
- R6: Word layout: bit 23 start flag, bit 22 end flag, bits 21:19 chip index, bits 18:14 channel index, bits 13:0 the sample.
- R7: The start flag is set only on word (chip 0, channel 0), and the end flag only on word (chip 5, channel 17).
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o stay unchanged on the next cycle.
- R9: busy_o rises on the accepting edge and falls on the edge that accepts the end-flagged word. A trigger while busy is ignored: it causes no extra words, and busy_o is still low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Event trigger |
| calib_i | input | 1 | Calibration mode request, captured at acceptance |
| hold_dly_i | input | 8 | Ticks from acceptance to hold edge |
| inj_lead_i | input | 8 | Ticks the injection pulse leads the hold edge |
| settle_i | input | 6 | Settling ticks after each select step |
| hold_o | output | 1 | Sample-and-hold strobe to the chips |
| inject_o | output | 1 | Charge-injection control |
| mux_sel_o | output | 5 | Shared channel select |
| conv_start_o | output | 1 | Converter start pulse |
| adc_valid_i | input | 1 | All converters have results |
| adc_data_i | input | 84 | Six 14-bit results, chip 0 in the low bits |
| busy_o | output | 1 | Event in progress |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts word |
| out_data_o | output | 24 | Tagged sample word |

## Verification
The bench measures the hold and injection edges to the exact tick against the programmed delays, including a one-tick delay and a lead longer than the delay. A design one tick off would shift the frozen sample away from the peak. The bench times every converter start against the settle count, including a settle of zero. A late or early start would sample a line that is still moving. The stream runs under random back-pressure and at full rate, and every word's tag, flags and sample are compared. A lost, repeated or misordered word therefore shows up, as does a channel mislabelled after a stall. A trigger sent in the middle of an event must leave no trace, which catches a design that restarts or appends a second event.

// File: rtl/fe_ro_pkg.sv
package fe_ro_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SETTLE,
    ST_CONV,
    ST_EMIT
  } ro_state_e;
endpackage

// File: rtl/fe_ro_bank.sv
module fe_ro_bank #(
  parameter int N_CHIP = 6,
  parameter int SMP_W  = 14,
  localparam int CHIP_W = $clog2(N_CHIP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_i,
  input  logic [N_CHIP*SMP_W-1:0] data_i,
  input  logic [CHIP_W-1:0]       sel_i,
  output logic [SMP_W-1:0]        smp_o
);
  logic [SMP_W-1:0] held [N_CHIP];

  for (genvar g = 0; g < N_CHIP; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)     held[g] <= '0;
      else if (cap_i) held[g] <= data_i[g*SMP_W +: SMP_W];
    end
  end

  always_comb begin
    smp_o = '0;
    for (int i = 0; i < N_CHIP; i++)
      if (sel_i == CHIP_W'(i)) smp_o = held[i];
  end
endmodule

// File: rtl/fe_ro_ctrl.sv
module fe_ro_ctrl
  import fe_ro_pkg::*;
#(
  parameter int N_CHIP = 6,
  parameter int N_CHAN = 18,
  parameter int DLY_W  = 8,
  parameter int SET_W  = 6,
  localparam int CHIP_W = $clog2(N_CHIP),
  localparam int CHAN_W = $clog2(N_CHAN),
  localparam int TMR_W  = ((DLY_W > SET_W) ? DLY_W : SET_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              calib_i,
  input  logic [DLY_W-1:0]  hold_dly_i,
  input  logic [DLY_W-1:0]  inj_lead_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic              adc_valid_i,
  input  logic              take_i,
  output logic              hold_o,
  output logic              inject_o,
  output logic              conv_o,
  output logic              busy_o,
  output logic              cap_o,
  output logic              emit_o,
  output logic              first_o,
  output logic              last_o,
  output logic [CHIP_W-1:0] chip_o,
  output logic [CHAN_W-1:0] chan_o
);
  ro_state_e         st;
  logic [TMR_W-1:0]  tmr;
  logic              cal_q, hold_q, inj_q, conv_q;
  logic [CHIP_W-1:0] chip_q;
  logic [CHAN_W-1:0] chan_q;

  logic [TMR_W-1:0] dly_x, lead_x, set_x;
  assign dly_x  = TMR_W'(hold_dly_i);
  assign lead_x = TMR_W'(inj_lead_i);
  assign set_x  = TMR_W'(settle_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tmr    <= '0;
      cal_q  <= 1'b0;
      hold_q <= 1'b0;
      inj_q  <= 1'b0;
      conv_q <= 1'b0;
      chip_q <= '0;
      chan_q <= '0;
    end else begin
      conv_q <= 1'b0;
      case (st)
        ST_IDLE: if (trig_i) begin
          st     <= ST_ARM;
          tmr    <= TMR_W'(1);
          cal_q  <= calib_i;
          inj_q  <= calib_i && (lead_x != '0) && (lead_x >= dly_x);
          chip_q <= '0;
          chan_q <= '0;
        end
        ST_ARM: begin
          if (tmr >= dly_x) begin
            hold_q <= 1'b1;
            inj_q  <= 1'b0;
            tmr    <= '0;
            st     <= ST_SETTLE;
          end else begin
            tmr <= tmr + 1'b1;
            if (cal_q && (lead_x != '0) && (tmr + lead_x >= dly_x)) inj_q <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tmr >= set_x) begin
            conv_q <= 1'b1;
            st     <= ST_CONV;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_CONV: if (adc_valid_i) begin
          chip_q <= '0;
          st     <= ST_EMIT;
        end
        ST_EMIT: if (take_i) begin
          if (chip_q == CHIP_W'(N_CHIP-1)) begin
            if (chan_q == CHAN_W'(N_CHAN-1)) begin
              hold_q <= 1'b0;
              st     <= ST_IDLE;
            end else begin
              chan_q <= chan_q + 1'b1;
              tmr    <= '0;
              st     <= ST_SETTLE;
            end
          end else begin
            chip_q <= chip_q + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign hold_o   = hold_q;
  assign inject_o = inj_q;
  assign conv_o   = conv_q;
  assign busy_o   = (st != ST_IDLE);
  assign cap_o    = (st == ST_CONV) && adc_valid_i;
  assign emit_o   = (st == ST_EMIT);
  assign chip_o   = chip_q;
  assign chan_o   = chan_q;
  assign first_o  = (chip_q == '0) && (chan_q == '0);
  assign last_o   = (chip_q == CHIP_W'(N_CHIP-1)) && (chan_q == CHAN_W'(N_CHAN-1));

  AST_INJECT_ENDS_AT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    inj_q |-> !hold_q); // R3
  AST_EMIT_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |-> hold_q); // R2
  AST_SELECT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_q < CHAN_W'(N_CHAN)); // R4
  AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q |=> !conv_q); // R4
  AST_CONV_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q |-> hold_q); // R4
endmodule

// File: rtl/fe_readout_seq.sv
module fe_readout_seq #(
  parameter int N_CHIP = 6,
  parameter int N_CHAN = 18,
  parameter int SMP_W  = 14,
  parameter int DLY_W  = 8,
  parameter int SET_W  = 6,
  localparam int CHIP_W = $clog2(N_CHIP),
  localparam int CHAN_W = $clog2(N_CHAN),
  localparam int WORD_W = 2 + CHIP_W + CHAN_W + SMP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_i,
  input  logic                    calib_i,
  input  logic [DLY_W-1:0]        hold_dly_i,
  input  logic [DLY_W-1:0]        inj_lead_i,
  input  logic [SET_W-1:0]        settle_i,
  output logic                    hold_o,
  output logic                    inject_o,
  output logic [CHAN_W-1:0]       mux_sel_o,
  output logic                    conv_start_o,
  input  logic                    adc_valid_i,
  input  logic [N_CHIP*SMP_W-1:0] adc_data_i,
  output logic                    busy_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [WORD_W-1:0]       out_data_o
);
  logic              cap, emit, first, last, take;
  logic [CHIP_W-1:0] chip;
  logic [CHAN_W-1:0] chan;
  logic [SMP_W-1:0]  smp;

  assign take = emit && out_ready_i;

  fe_ro_ctrl #(
    .N_CHIP(N_CHIP), .N_CHAN(N_CHAN), .DLY_W(DLY_W), .SET_W(SET_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .calib_i(calib_i),
    .hold_dly_i(hold_dly_i), .inj_lead_i(inj_lead_i), .settle_i(settle_i),
    .adc_valid_i(adc_valid_i), .take_i(take),
    .hold_o(hold_o), .inject_o(inject_o), .conv_o(conv_start_o),
    .busy_o(busy_o), .cap_o(cap), .emit_o(emit),
    .first_o(first), .last_o(last), .chip_o(chip), .chan_o(chan)
  );

  fe_ro_bank #(.N_CHIP(N_CHIP), .SMP_W(SMP_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .data_i(adc_data_i),
    .sel_i(chip), .smp_o(smp)
  );

  assign mux_sel_o   = chan;
  assign out_valid_o = emit;
  assign out_data_o  = {first, last, chip, chan, smp};

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R8
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> busy_o); // R9
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !(out_data_o[WORD_W-1] && out_data_o[WORD_W-2])); // R7
endmodule

// File: tb/fe_readout_seq_tb.sv
module fe_readout_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        trig = 0, calib = 0, adc_valid = 0, ready = 0;
  logic [7:0]  hold_dly = 8'd18, inj_lead = 8'd0;
  logic [5:0]  settle = 6'd3;
  logic [83:0] adc_data = '0;
  logic        hold, inject, conv, busy, valid;
  logic [4:0]  mux;
  logic [23:0] word;

  int checks = 0, errors = 0;
  int cyc = 0, ev_id = 0, ev_done = 0, widx = 0, ready_pct = 100;
  int adc_cnt = 0, t_trig = 0, t_hold = -1, t_inj = -1, inj_rises = 0, since = 0;
  logic prev_hold = 0, prev_conv = 0, idle_check = 0, finished = 0;
  logic [4:0] prev_mux = 0;

  fe_readout_seq u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .calib_i(calib),
    .hold_dly_i(hold_dly), .inj_lead_i(inj_lead), .settle_i(settle),
    .hold_o(hold), .inject_o(inject), .mux_sel_o(mux), .conv_start_o(conv),
    .adc_valid_i(adc_valid), .adc_data_i(adc_data), .busy_o(busy),
    .out_valid_o(valid), .out_ready_i(ready), .out_data_o(word)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [13:0] smp(int ev, int chip, int chan);
    int v = ev * 977 + chip * 1531 + chan * 211 + 3;
    return v[13:0];
  endfunction

  function automatic logic [23:0] exp_word(int ev, int idx);
    int chip = idx % 6, chan = idx / 6;
    return {(idx == 0), (idx == 107), 3'(chip), 5'(chan), smp(ev, chip, chan)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // converter model: all six results arrive together after a random latency
  always @(negedge clk) begin
    adc_valid = 0;
    if (adc_cnt > 0) begin
      adc_cnt--;
      if (adc_cnt == 0) begin
        adc_valid = 1;
        for (int c = 0; c < 6; c++) adc_data[c*14 +: 14] = smp(ev_id, c, int'(mux));
      end
    end
    if (conv && !prev_conv) adc_cnt = 1 + int'($urandom % 3);
  end

  // stream sink with back-pressure, checks every accepted word
  always @(negedge clk) begin
    if (idle_check) begin
      check("R9 busy falls after end word", busy, 0);
      idle_check = 0;
    end
    ready = (int'($urandom % 100) < ready_pct);
    if (valid && rst_n) begin
      check("R9 busy during stream", busy, 1);
      if (ready) begin
        check("R5 R6 R7 word", word, exp_word(ev_id, widx));
        widx++;
        if (widx == 108) begin
          widx = 0;
          ev_done++;
          idle_check = 1;
        end
      end
    end
  end

  // timing monitor: hold, inject and settle
  always @(negedge clk) begin
    if (rst_n) begin
      if (mux != prev_mux || (hold && !prev_hold)) since = 0;
      else since++;
      if (hold && !prev_hold) t_hold = cyc;
      if (inject && t_inj < 0) begin t_inj = cyc; inj_rises++; end
      if (conv && !prev_conv) check("R4 settle time", since, int'(settle) + 1);
    end
    prev_hold = hold; prev_conv = conv; prev_mux = mux;
  end

  task automatic run_event(int hd, int ld, bit cal, int st, int rp, bit retrig);
    int target;
    hold_dly = 8'(hd); inj_lead = 8'(ld); settle = 6'(st); calib = cal;
    ready_pct = rp; ev_id++;
    t_hold = -1; t_inj = -1; inj_rises = 0;
    target = ev_done + 1;
    @(negedge clk);
    trig = 1; t_trig = cyc;
    @(negedge clk);
    trig = 0;
    check("R9 busy rises", busy, 1);
    if (retrig) begin
      wait (widx == 50);
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 0;
    end
    wait (ev_done == target);
    check("R2 hold delay", t_hold - t_trig, ((hd < 1) ? 1 : hd) + 1);
    if (cal && ld != 0) begin
      check("R3 inject lead", t_inj - t_trig, ((hd - ld < 0) ? 0 : hd - ld) + 1);
      check("R3 single pulse", inj_rises, 1);
    end else check("R3 no inject", inj_rises, 0);
    repeat (40) @(negedge clk);
    check("R9 idle after event", busy, 0);
    check("R9 no extra words", valid, 0);
    check("R2 hold released", hold, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 hold", hold, 0);
    check("R1 inject", inject, 0);
    check("R1 conv", conv, 0);
    check("R1 valid", valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_event(18, 0, 0, 3, 70, 0);   // nominal peak delay
    run_event(18, 5, 1, 3, 60, 0);   // calibration pulse
    run_event(1, 0, 0, 0, 100, 0);   // shortest delay, no settle, full rate
    run_event(4, 9, 1, 2, 50, 1);    // lead beyond delay, retrigger while busy
    run_event(12, 7, 0, 1, 80, 0);   // lead set but calibration off
    for (int k = 0; k < 3; k++)
      run_event(1 + int'($urandom % 40), int'($urandom % 20), 1'($urandom % 2),
                int'($urandom % 8), 30 + int'($urandom % 71), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule